// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block fades a group of audio output channels between full level and silence without clicks. It holds a linear gain counter that moves by one step on each output frame strobe, toward zero while muting is requested and toward the full-scale value of the chosen ramp length otherwise. Every channel sample is scaled by the same gain. All ramp lengths are powers of two, so the scaling is a multiply followed by an arithmetic shift.

A mute request that is withdrawn part way down reverses the ramp from wherever the gain currently is, at the same one-step-per-frame rate. In the self-releasing mode, the block keeps its outputs silent for a fixed number of frames after reset is released. It then ramps up by itself, unless the mute input is still high.

Top module: `soft_mute_ramp`

## Requirements
- R1: While rst_ni is low, gain_o is 0, muted_o is 1 and every channel of samples_o is 0.
- R2: period_sel_i code c (0 to 3) sets the full-scale gain to 1024 << c, so a full ramp takes 1024, 2048, 4096 or 8192 frame strobes; the gain never goes above that value.
- R3: With the effective mute high, each frame strobe lowers gain_o by 1 until it reaches 0, where it stays.
- R4: With the effective mute low, each frame strobe raises gain_o by 1 until it reaches the full-scale value, where it stays.
- R5: Releasing mute part way down makes the gain climb back from its current value, one step per strobe.
- R6: A cycle without frame_i leaves gain_o unchanged.
- R7: One clock after a sample is presented, channel k of samples_o (bits [k*24 +: 24], two's complement) equals floor(sample_k * gain_o / full_scale); at full scale the sample passes through unchanged and at gain 0 the output is 0.
- R8: All channels are scaled by the same gain.
- R9: With semi_auto_i high, gain_o stays 0 for the first 4410 frame strobes after reset release, and the ramp up starts on strobe 4411.
- R10: With semi_auto_i high and mute_i high when the hold ends, the gain stays at 0 until mute_i goes low, and then it ramps up.
- R11: muted_o is 1 exactly when gain_o is 0.
- R12: With semi_auto_i low and mute_i low, the ramp up starts on the first frame strobe after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | One-cycle output frame strobe; advances the ramp |
| mute_i | input | 1 | Mute request, high to fade out |
| semi_auto_i | input | 1 | Selects the self-releasing mode after reset |
| period_sel_i | input | 2 | Ramp length code, 0 to 3 |
| samples_i | input | NUM_CH*DATA_W | Channel samples, channel k at [k*DATA_W +: DATA_W] |
| gain_o | output | BASE_LOG2+4 | Current gain counter |
| samples_o | output | NUM_CH*DATA_W | Scaled channel samples, registered |
| muted_o | output | 1 | High when the gain is zero |

## Verification
The gain counter takes its new value on the rising edge that samples a frame strobe. Every gain check is therefore made at the falling edge after the last strobed edge, never at the edge itself. The scaled samples pass through one register beyond the gain. Scaling checks hold frame_i low, present the samples at a falling edge and compare one full clock later, once the gain is fixed. Long ramps drive the strobe on every cycle, so the expected gain is a plain count of strobes, clamped to 0 and to the full-scale value.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned SEL_MAX = (1 << SEL_W) - 1;

  function automatic int unsigned gain_bits(int unsigned base_log2);
    return base_log2 + SEL_MAX + 1;
  endfunction
endpackage

// File: rtl/smr_hold_timer.sv
module smr_hold_timer #(
  parameter int unsigned HOLD_FRAMES = 4410
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic hold_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_FRAMES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign hold_o = (cnt_q != CNT_W'(HOLD_FRAMES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (frame_i && hold_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/smr_gain_ramp.sv
module smr_gain_ramp
  import smr_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned GAIN_W    = gain_bits(BASE_LOG2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              mute_i,
  input  logic [SEL_W-1:0]  period_sel_i,
  output logic [GAIN_W-1:0] gain_o
);
  logic [GAIN_W-1:0] limit;
  logic [GAIN_W-1:0] gain_q, gain_d;

  assign limit = GAIN_W'(1) << (BASE_LOG2 + period_sel_i);

  always_comb begin
    gain_d = gain_q;
    if (gain_q > limit) begin
      gain_d = limit;  // select changed against the rules: clamp
    end else if (mute_i) begin
      if (gain_q != '0) gain_d = gain_q - 1'b1;
    end else if (gain_q != limit) begin
      gain_d = gain_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gain_q <= '0;
    else if (step_i) gain_q <= gain_d;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler
  import smr_pkg::*;
#(
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned BASE_LOG2 = 10,
  parameter int unsigned GAIN_W    = gain_bits(BASE_LOG2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [SEL_W-1:0]  period_sel_i,
  output logic [DATA_W-1:0] sample_o
);
  localparam int unsigned PROD_W = DATA_W + GAIN_W + 1;
  localparam int unsigned SH_W   = $clog2(BASE_LOG2 + SEL_MAX + 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [DATA_W-1:0] scaled;
  logic        [SH_W-1:0]   shamt;

  assign shamt  = SH_W'(BASE_LOG2) + SH_W'(period_sel_i);
  assign prod   = $signed(sample_i) * $signed({1'b0, gain_i});
  assign scaled = DATA_W'(prod >>> shamt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else         sample_o <= scaled;
  end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int unsigned NUM_CH      = 6,
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned BASE_LOG2   = 10,
  parameter int unsigned HOLD_FRAMES = 4410,
  localparam int unsigned GAIN_W     = gain_bits(BASE_LOG2),
  localparam int unsigned BUS_W      = NUM_CH * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              mute_i,
  input  logic              semi_auto_i,
  input  logic [SEL_W-1:0]  period_sel_i,
  input  logic [BUS_W-1:0]  samples_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [BUS_W-1:0]  samples_o,
  output logic              muted_o
);
  logic hold_active;
  logic eff_mute;
  logic [GAIN_W-1:0] gain;

  smr_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frame_i(frame_i),
    .hold_o (hold_active)
  );

  assign eff_mute = mute_i | (semi_auto_i & hold_active);

  smr_gain_ramp #(.BASE_LOG2(BASE_LOG2), .GAIN_W(GAIN_W)) u_ramp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (frame_i),
    .mute_i      (eff_mute),
    .period_sel_i(period_sel_i),
    .gain_o      (gain)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    smr_scaler #(.DATA_W(DATA_W), .BASE_LOG2(BASE_LOG2), .GAIN_W(GAIN_W)) u_scale (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sample_i    (samples_i[ch*DATA_W +: DATA_W]),
      .gain_i      (gain),
      .period_sel_i(period_sel_i),
      .sample_o    (samples_o[ch*DATA_W +: DATA_W])
    );
  end

  assign gain_o  = gain;
  assign muted_o = (gain == '0);
endmodule

// File: rtl/smr_checker.sv
module smr_checker
  import smr_pkg::*;
#(
  parameter int unsigned BASE_LOG2   = 10,
  parameter int unsigned HOLD_FRAMES = 4410,
  parameter int unsigned GAIN_W      = gain_bits(BASE_LOG2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic              mute_i,
  input logic              semi_auto_i,
  input logic [SEL_W-1:0]  period_sel_i,
  input logic [GAIN_W-1:0] gain_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_FRAMES + 1);

  logic [CNT_W-1:0]  fr_q;
  logic [GAIN_W-1:0] limit;

  assign limit = GAIN_W'(1) << (BASE_LOG2 + period_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   fr_q <= '0;
    else if (frame_i && fr_q != CNT_W'(HOLD_FRAMES)) fr_q <= fr_q + 1'b1;
  end

  assert_gain_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= limit);

  assert_mute_steps_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mute_i && gain_o != '0) |=> (gain_o == $past(gain_o) - GAIN_W'(1)));

  assert_unmute_steps_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !mute_i && !semi_auto_i && gain_o < limit)
      |=> (gain_o == $past(gain_o) + GAIN_W'(1)));

  assert_idle_holds_gain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(gain_o));

  assert_hold_keeps_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (semi_auto_i && fr_q != CNT_W'(HOLD_FRAMES)) |-> (gain_o == '0));
endmodule

bind soft_mute_ramp smr_checker #(
  .BASE_LOG2  (BASE_LOG2),
  .HOLD_FRAMES(HOLD_FRAMES),
  .GAIN_W     (GAIN_W)
) u_smr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_i     (frame_i),
  .mute_i      (mute_i),
  .semi_auto_i (semi_auto_i),
  .period_sel_i(period_sel_i),
  .gain_o      (gain_o)
);

// File: tb/soft_mute_ramp_tb_top.sv
`timescale 1ns/1ps
module soft_mute_ramp_tb_top;
  localparam int NUM_CH = 6;
  localparam int DW     = 24;
  localparam int GW     = 14;
  localparam int BUS_W  = NUM_CH * DW;
  localparam int VEC_N  = 8;

  typedef struct packed {
    logic signed [DW-1:0] smp;
    logic signed [DW-1:0] exp;
  } vec_t;

  // samples scaled at gain 512 of full scale 1024: floor(s/2)
  localparam vec_t VECS [VEC_N] = '{
    '{ 24'sd1000,     24'sd500     },
    '{-24'sd1000,    -24'sd500     },
    '{ 24'sd1,        24'sd0       },
    '{-24'sd1,       -24'sd1       },
    '{ 24'sd3,        24'sd1       },
    '{-24'sd3,       -24'sd2       },
    '{ 24'sd8388607,  24'sd4194303 },
    '{-24'sd8388608, -24'sd4194304 }
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frame;
  logic             mute;
  logic             semi;
  logic [1:0]       sel;
  logic [BUS_W-1:0] samples_in;
  logic [GW-1:0]    gain;
  logic [BUS_W-1:0] samples_out;
  logic             muted;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  soft_mute_ramp dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_i     (frame),
    .mute_i      (mute),
    .semi_auto_i (semi),
    .period_sel_i(sel),
    .samples_i   (samples_in),
    .gain_o      (gain),
    .samples_o   (samples_out),
    .muted_o     (muted)
  );

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic frames(int n);
    frame = 1'b1;
    repeat (n) @(negedge clk);
    frame = 1'b0;
  endtask

  function automatic longint ch_out(int ch);
    return longint'($signed(samples_out[ch*DW +: DW]));
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; frame = 1'b0; mute = 1'b0; semi = 1'b0; sel = 2'd0;
    samples_in = '0;
    for (int ch = 0; ch < NUM_CH; ch++) samples_in[ch*DW +: DW] = 24'sd77;
    repeat (3) @(negedge clk);
    check("R1 gain in reset", gain, 0);
    check("R1 muted in reset", muted, 1);
    check("R1 samples in reset", samples_out, 0);
    rst_n = 1'b1;

    frames(512);
    check("R12 manual ramp starts at once", gain, 512);
    check("R11 not muted", muted, 0);

    // table walk: scaling at half gain, per channel rotation (R7, R8)
    for (int i = 0; i < VEC_N; i++) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        samples_in[ch*DW +: DW] = VECS[(i + ch) % VEC_N].smp;
      @(negedge clk);
      for (int ch = 0; ch < NUM_CH; ch++)
        check("R7 R8 scaled sample", ch_out(ch), longint'(VECS[(i + ch) % VEC_N].exp));
    end

    repeat (10) @(negedge clk);
    check("R6 no strobe holds gain", gain, 512);

    frames(600);
    check("R4 saturates at unity", gain, 1024);
    for (int ch = 0; ch < NUM_CH; ch++)
      samples_in[ch*DW +: DW] = (ch % 2 == 0) ? -24'sd8388608 : 24'sd8388607 - DW'(ch);
    @(negedge clk);
    for (int ch = 0; ch < NUM_CH; ch++)
      check("R7 unity passthrough", ch_out(ch),
            (ch % 2 == 0) ? -64'sd8388608 : 64'sd8388607 - ch);

    mute = 1'b1;
    frames(100);
    check("R3 ramp down", gain, 924);
    mute = 1'b0;
    frames(50);
    check("R5 reverse from current level", gain, 974);
    mute = 1'b1;
    frames(1000);
    check("R3 floor at zero", gain, 0);
    check("R11 muted at zero", muted, 1);
    @(negedge clk);
    check("R7 zero gain silences", samples_out, 0);

    sel = 2'd3; mute = 1'b0;
    frames(8191);
    check("R2 code 3 one below full", gain, 8191);
    frames(5);
    check("R2 code 3 full scale 8192", gain, 8192);
    mute = 1'b1;
    frames(8192);
    check("R3 full ramp down code 3", gain, 0);
    sel = 2'd1; mute = 1'b0;
    frames(2050);
    check("R2 code 1 full scale 2048", gain, 2048);

    rst_n = 1'b0;
    #1;
    check("R1 async reset clears gain", gain, 0);
    semi = 1'b1; sel = 2'd0; mute = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    frames(4410);
    check("R9 silent through hold", gain, 0);
    check("R11 muted through hold", muted, 1);
    frames(1);
    check("R9 first step after hold", gain, 1);
    frames(9);
    check("R9 ramp continues", gain, 10);

    rst_n = 1'b0;
    mute = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    frames(4500);
    check("R10 mute high keeps silence", gain, 0);
    mute = 1'b0;
    frames(3);
    check("R10 ramp after mute release", gain, 3);

    finish_run();
  end
endmodule